// File: doc/BRIEF.md
# Watchdog Timer With Timed Unlock

This block is a watchdog counter that software keeps alive by kicking it. One small control register sets whether the watchdog runs and which of eight timeout periods applies. If no kick or register write arrives within the selected period, the block raises a single-cycle bite pulse that the chip uses to start a reset. A free-running tick input stands in for the slow watchdog oscillator, and every timeout is counted in ticks.

Turning the watchdog on is always allowed. Turning it off, or changing its period, takes two writes. The first write opens a short change window. The second write must land within that window. A stray write therefore cannot silence the watchdog or stretch its timeout.

Top module: `guard_timer`

## Requirements
- R1: After reset, `ctl_rd` reads 0 and `bite` is low. The register layout is: bit 0 `run`, bit 1 `unlock`, bits 4:2 `span`.
- R2: Any write with `unlock`=0 and `run`=1 sets `run` to 1, with no sequence needed.
- R3: A write that clears `run` outside an open window leaves `run` unchanged.
- R4: A write with both `unlock`=1 and `run`=1 opens the window, reads back `unlock`=1 and forces `run`=1. A write with `unlock`=1 and `run`=0 opens nothing and changes no field.
- R5: A write with `unlock`=0 while the window is open loads `run` and `span` from the write data and closes the window.
- R6: An unused window closes by itself. Writes on the four clock edges after the opening write are honoured. From the fifth edge on, `unlock` reads 0.
- R7: Outside an open window, writes leave `span` unchanged.
- R8: While `run`=1, the watchdog bites after 2^(BASE_EXP+span) tick cycles with no clear. The bite is exactly one cycle long, and counting then restarts.
- R9: A kick or any register write restarts the count and suppresses a bite on that edge.
- R10: While `run`=0, no bite occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Watchdog time base, one count per high cycle |
| kick | input | 1 | Restart the timeout count |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2+SPAN_W | Write data: {span, unlock, run} |
| ctl_rd | output | 2+SPAN_W | Current register value |
| bite | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block with BASE_EXP set to 2, so the shortest period is 4 ticks and the longest is 512. All eight span values can then reach expiry within a short run. The change window keeps its default length of four. The bench probes the window by idling three and then four cycles before the second write, which covers the first rejected edge. Random writes, unlocks, kicks and tick gaps are mixed with directed sequences.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  typedef enum logic [1:0] {
    OP_NONE,
    OP_OPEN,
    OP_COMMIT,
    OP_PLAIN
  } wr_op_e;

  function automatic int unsigned span_ticks(input int unsigned base_exp,
                                             input int unsigned span);
    return 32'd1 << (base_exp + span);
  endfunction

  function automatic wr_op_e classify(input logic we, input logic run_bit,
                                      input logic unl_bit, input logic win_open);
    if (!we)                   return OP_NONE;
    if (unl_bit && run_bit)    return OP_OPEN;
    if (!unl_bit && win_open)  return OP_COMMIT;
    if (!unl_bit)              return OP_PLAIN;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/guard_timer_ctl.sv
module guard_timer_ctl #(
  parameter int SPAN_W = 3,
  parameter int WIN    = 4,
  localparam int REG_W = 2 + SPAN_W,
  localparam int WIN_W = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic              run,
  output logic              unl,
  output logic [SPAN_W-1:0] span,
  output logic              win_last,
  output logic              unlock_hit
);
  import guard_timer_pkg::*;

  logic [WIN_W-1:0] left_q;
  wr_op_e           op;

  assign op         = classify(wr_en, wr_data[0], wr_data[1], unl);
  assign unlock_hit = (op == OP_OPEN);
  assign win_last   = unl && (left_q == WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      unl    <= 1'b0;
      span   <= '0;
      left_q <= '0;
    end else begin
      case (op)
        OP_OPEN: begin
          run    <= 1'b1;
          unl    <= 1'b1;
          left_q <= WIN_W'(WIN);
        end
        OP_COMMIT: begin
          run    <= wr_data[0];
          span   <= wr_data[REG_W-1:2];
          unl    <= 1'b0;
          left_q <= '0;
        end
        default: begin
          if (op == OP_PLAIN && wr_data[0]) run <= 1'b1;
          if (unl) begin
            left_q <= left_q - WIN_W'(1);
            if (win_last) unl <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/guard_timer_cnt.sv
module guard_timer_cnt #(
  parameter int SPAN_W   = 3,
  parameter int BASE_EXP = 10,
  localparam int CNT_W   = BASE_EXP + (1 << SPAN_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              restart,
  input  logic [SPAN_W-1:0] span,
  output logic              expire,
  output logic              bite
);
  import guard_timer_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(span_ticks(BASE_EXP, span) - 1));
  assign expire = run && tick && !restart && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bite  <= 1'b0;
    end else begin
      bite <= expire;
      if (restart || !run)  cnt_q <= '0;
      else if (tick)        cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int SPAN_W   = 3,
  parameter int BASE_EXP = 10,
  parameter int WIN      = 4,
  localparam int REG_W   = 2 + SPAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_rd,
  output logic             bite
);
  logic              run;
  logic              unl;
  logic [SPAN_W-1:0] span;
  logic              win_last;
  logic              unlock_hit;
  logic              restart;
  logic              expire;

  assign restart = kick || wr_en;
  assign ctl_rd  = {span, unl, run};

  guard_timer_ctl #(.SPAN_W(SPAN_W), .WIN(WIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .run(run), .unl(unl), .span(span),
    .win_last(win_last), .unlock_hit(unlock_hit)
  );

  guard_timer_cnt #(.SPAN_W(SPAN_W), .BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .restart(restart),
    .span(span), .expire(expire), .bite(bite)
  );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int SPAN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick,
  input logic              run,
  input logic              unl,
  input logic [SPAN_W-1:0] span,
  input logic              bite,
  input logic              win_last,
  input logic              unlock_hit
);
  a_r3_run_holds_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !unl) |=> run);

  a_r7_span_holds_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unl |=> $stable(span));

  a_r6_window_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !unlock_hit) |=> !unl);

  a_r4_open_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_hit |=> (unl && run));

  a_r8_bite_single: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> !bite);

  a_r10_idle_no_bite: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bite);

  a_r9_kick_no_bite: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !bite);
endmodule

bind guard_timer guard_timer_chk #(.SPAN_W(SPAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .run(run), .unl(unl), .span(span),
  .bite(bite), .win_last(win_last), .unlock_hit(unlock_hit)
);

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;
  localparam int SPAN_W = 3;
  localparam int BASE   = 2;
  localparam int WINL   = 4;
  localparam int REG_W  = 2 + SPAN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, kick = 1'b0, wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] ctl_rd;
  logic bite;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit m_on, m_unl, m_bite;
  int m_left, m_sel, m_rem;

  always #2.5 clk = ~clk;

  guard_timer #(.SPAN_W(SPAN_W), .BASE_EXP(BASE), .WIN(WINL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .wr_en(wr_en),
    .wr_data(wr_data), .ctl_rd(ctl_rd), .bite(bite)
  );

  function automatic logic [REG_W-1:0] enc(input bit on, input bit un, input int sel);
    return {SPAN_W'(sel), un, on};
  endfunction

  function automatic int period(input int sel);
    int p = 1;
    for (int i = 0; i < BASE + sel; i++) p = p * 2;
    return p;
  endfunction

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit we, input logic [REG_W-1:0] d,
                            input bit kk, input bit tk);
    bit old_on = m_on;
    if (we && d[1] && d[0]) begin
      m_on = 1; m_unl = 1; m_left = WINL;
    end else if (we && !d[1] && m_unl) begin
      m_on = d[0]; m_sel = int'(d[REG_W-1:2]); m_unl = 0;
    end else begin
      if (we && !d[1] && d[0]) m_on = 1;
      if (m_unl) begin
        m_left--;
        if (m_left == 0) m_unl = 0;
      end
    end
    m_bite = 0;
    if (we || kk || !old_on) m_rem = period(m_sel);
    else if (tk) begin
      if (m_rem == 1) begin m_bite = 1; m_rem = period(m_sel); end
      else m_rem--;
    end
  endtask

  task automatic cyc(input string tag, input bit we, input logic [REG_W-1:0] d,
                     input bit kk, input bit tk);
    wr_en = we; wr_data = d; kick = kk; tick = tk;
    @(posedge clk);
    model_step(we, d, kk, tk);
    @(negedge clk);
    wr_en = 0; kick = 0;
    expect_eq({tag, " reg"}, int'(ctl_rd), int'(enc(m_on, m_unl, m_sel)));
    expect_eq({tag, " bite"}, int'(bite), int'(m_bite));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_on = 0; m_unl = 0; m_left = 0; m_sel = 0; m_rem = period(0); m_bite = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int bites;
    void'($urandom(32'd1234));
    do_reset();
    expect_eq("R1 reset reg", int'(ctl_rd), 0);
    expect_eq("R1 reset bite", int'(bite), 0);

    cyc("R2 enable", 1, enc(1, 0, 1), 0, 1);
    expect_eq("R2/R7 enable no sel", int'(ctl_rd), int'(enc(1, 0, 0)));
    cyc("R3 locked clear", 1, enc(0, 0, 5), 0, 1);
    expect_eq("R3/R7 locked clear ignored", int'(ctl_rd), int'(enc(1, 0, 0)));

    cyc("R4 open", 1, enc(1, 1, 0), 0, 1);
    expect_eq("R4 window open", int'(ctl_rd), int'(enc(1, 1, 0)));
    repeat (3) cyc("R6 idle", 0, '0, 0, 1);
    cyc("R5 commit late", 1, enc(1, 0, 2), 0, 1);
    expect_eq("R5 commit at edge 4", int'(ctl_rd), int'(enc(1, 0, 2)));

    cyc("R4 reopen", 1, enc(1, 1, 0), 0, 1);
    repeat (4) cyc("R6 idle", 0, '0, 0, 1);
    expect_eq("R6 window closed", int'(ctl_rd), int'(enc(1, 0, 2)));
    cyc("R3 after close", 1, enc(0, 0, 0), 0, 1);
    expect_eq("R3 clear after close ignored", int'(ctl_rd), int'(enc(1, 0, 2)));

    cyc("R4 half open", 1, enc(0, 1, 7), 0, 1);
    expect_eq("R4 unlock without run", int'(ctl_rd), int'(enc(1, 0, 2)));

    cyc("R4 open", 1, enc(1, 1, 0), 0, 1);
    cyc("R5 disable", 1, enc(0, 0, 0), 0, 1);
    expect_eq("R5 disabled", int'(ctl_rd), 0);
    bites = 0;
    repeat (20) begin cyc("R10 idle", 0, '0, 0, 1); bites += int'(bite); end
    expect_eq("R10 no bite while off", bites, 0);

    cyc("R2 enable", 1, enc(1, 0, 0), 0, 1);
    bites = 0;
    repeat (12) begin cyc("R8 run", 0, '0, 0, 1); bites += int'(bite); end
    expect_eq("R8 three bites in 12 ticks", bites, 3);

    bites = 0;
    repeat (10) begin
      cyc("R9 kick", 0, '0, 0, 1);
      cyc("R9 kick", 0, '0, 1, 1);
      bites += int'(bite);
    end
    expect_eq("R9 kicks hold off bite", bites, 0);

    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit we = 0;
      logic [REG_W-1:0] d = '0;
      if (r < 4) begin we = 1; d = enc(1, 1, 0); end
      else if (r < 9) begin we = 1; d = REG_W'($urandom); end
      cyc("R8 random", we, d, ($urandom_range(0, 199) == 0), ($urandom_range(0, 9) < 8));
    end

    for (int s = 0; s < 8; s++) begin
      cyc("R4 open", 1, enc(1, 1, 0), 0, 1);
      cyc("R5 set span", 1, enc(1, 0, s), 0, 1);
      repeat (period(s) + 2) cyc("R8 span sweep", 0, '0, 0, 1);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule